// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block turns one DMA parameter set into a stream of address beats. Each beat names a source byte address, a destination byte address and a byte count, and a bus master downstream moves that many bytes. The set describes a three-level nest: bytes per array, arrays per frame and frames per block. Each side, source and destination, has its own signed byte stride between arrays and its own signed byte stride between frames. A side may instead be held at a constant address, which suits a peripheral FIFO. With zero strides, every beat targets the same register.

A synchronization event releases work in one of two granularities. In array-synchronized mode each event releases a single array. In frame-synchronized mode each event releases a whole frame, issued as one array per cycle. An event that arrives while work is still being issued is remembered and serviced afterwards. When the last array of the block has been issued, the sequencer can raise a one-cycle completion pulse carrying a completion code.

The controller has four states. `S_IDLE` waits for a parameter load. An accepted load (`load_ok`) moves to `S_WAIT`. `S_WAIT` moves to `S_ISSUE` on a new event or a held one (`go`). `S_ISSUE` produces one beat per cycle. From there it moves to `S_FINISH` on the block's last array. It returns to `S_WAIT` after a single array in array mode, or at a frame's end in frame mode. Otherwise it stays in `S_ISSUE`. `S_FINISH` lasts one cycle and returns to `S_IDLE`.

Top module: `dma3d_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `beat_valid` and `done_pulse` are all 0.
- R2: Field layout and load rules:
  - `cfg_ab_cnt` carries bytes per array in bits 15:0 and arrays per frame in bits 31:16.
  - A load is taken only in idle, and it raises `busy` on the next cycle.
  - A load with any of the three counts equal to zero is ignored: `busy` stays 0 and no beat appears.
- R3: Array-synchronized mode is selected when option bit 2 is 0. In it, each event yields exactly one beat. Inside a frame, each side moves by its array stride. The source stride is bits 15:0 of `cfg_a_stride` and the destination stride is bits 31:16.
- R4: At the end of a frame in array-synchronized mode:
  - The next frame begins at the last array's address plus the frame stride. The source frame stride is bits 15:0 of `cfg_f_stride` and the destination frame stride is bits 31:16.
  - Later frames use `cfg_reload` as their array count.
  - A reload value of 0 reuses the loaded arrays-per-frame count.
- R5: Frame-synchronized mode is selected when option bit 2 is 1. In it, each event yields a whole frame's beats on consecutive cycles. The next frame begins at the previous frame's start plus the frame stride.
- R6: Strides are sign-extended 16-bit values, so negative strides walk addresses downward.
- R7: Option bit 0 holds the source address constant, and option bit 1 holds the destination address constant, for the whole block.
- R8: Every beat carries the bytes-per-array count on `beat_bytes` and option bits 10:8 on `beat_fifo_w`.
- R9: Completion signalling:
  - When option bit 20 is 1, `done_pulse` is high for exactly the one cycle after the final beat, with `done_code` equal to option bits 17:12.
  - When option bit 20 is 0, no pulse occurs.
  - `busy` falls on the following cycle.
- R10: An event that arrives during a beat cycle is held and serviced once issuing stops. Further events arriving while one is held merge into it.
- R11: Events while idle are ignored: no beat is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the parameter set and arm the sequencer |
| cfg_opt | input | 32 | Option word: source constant, destination constant, sync mode, FIFO width, completion code and completion enable |
| cfg_src | input | AW | Source base byte address |
| cfg_dst | input | AW | Destination base byte address |
| cfg_ab_cnt | input | 2*CW | Bytes per array (low half) and arrays per frame (high half) |
| cfg_c_cnt | input | CW | Frames per block |
| cfg_a_stride | input | 2*CW | Array strides: source (low half) and destination (high half) |
| cfg_f_stride | input | 2*CW | Frame strides: source (low half) and destination (high half) |
| cfg_reload | input | CW | Arrays-per-frame reload for array-synchronized mode |
| sync_evt | input | 1 | Synchronization event |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_src | output | AW | Source byte address of the beat |
| beat_dst | output | AW | Destination byte address of the beat |
| beat_bytes | output | CW | Byte count of the beat |
| beat_fifo_w | output | 3 | Access width code for constant-address sides |
| busy | output | 1 | A parameter set is armed or in progress |
| done_pulse | output | 1 | One-cycle completion indication |
| done_code | output | 6 | Completion code accompanying the pulse |

## Verification
Transfers cover a range of cases, and each is told apart by its address sequence:
- Array-synchronized transfers with positive strides and a reload that differs from the first frame's count. These separate "frame stride from the last array" from "frame stride from the frame start", and show where the reload takes effect.
- A reload of zero, which must fall back to the loaded count.
- Negative strides in frame-synchronized mode, which expose missing sign extension.
- A constant-address destination, and a pair of all-zero strides.
- Back-to-back events, which show whether a held event is lost.

Rejected loads, idle events and a disabled completion enable are shown to have no effect through `busy`, the beat stream and `done_pulse`.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

    localparam int OPT_SRC_CONST = 0;
    localparam int OPT_DST_CONST = 1;
    localparam int OPT_FRAME_SYNC = 2;
    localparam int OPT_FW_LO = 8;
    localparam int OPT_FW_W = 3;
    localparam int OPT_CODE_LO = 12;
    localparam int OPT_CODE_W = 6;
    localparam int OPT_DONE_EN = 20;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_ISSUE,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/dma3d_count_ctl.sv
module dma3d_count_ctl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          frame_sync,
    input  logic [CW-1:0] bcnt,
    input  logic [CW-1:0] ccnt,
    input  logic [CW-1:0] reload,
    input  logic          step,
    input  logic          active,
    output logic          last_arr,
    output logic          last_blk
);
    logic [CW-1:0] brem_q, crem_q, bcnt_q, rld_q;
    logic          fsync_q;
    logic [CW-1:0] next_frame_cnt;

    // R4: a zero reload falls back to the loaded arrays-per-frame count.
    always_comb begin
        if (fsync_q)
            next_frame_cnt = bcnt_q;
        else if (rld_q == '0)
            next_frame_cnt = bcnt_q;
        else
            next_frame_cnt = rld_q;
    end

    assign last_arr = (brem_q == CW'(1));
    assign last_blk = last_arr && (crem_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brem_q  <= '0;
            crem_q  <= '0;
            bcnt_q  <= '0;
            rld_q   <= '0;
            fsync_q <= 1'b0;
        end else if (load) begin
            brem_q  <= bcnt;
            crem_q  <= ccnt;
            bcnt_q  <= bcnt;
            rld_q   <= reload;
            fsync_q <= frame_sync;
        end else if (step) begin
            if (!last_arr) begin
                brem_q <= brem_q - CW'(1);
            end else if (crem_q != CW'(1)) begin
                crem_q <= crem_q - CW'(1);
                brem_q <= next_frame_cnt;
            end
        end
    end

    // R2: counts stay nonzero while a block is armed
    p_counts_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (brem_q != '0) && (crem_q != '0));

endmodule

// File: rtl/dma3d_addr_side.sv
module dma3d_addr_side #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          hold_const,
    input  logic          frame_sync,
    input  logic [SW-1:0] arr_stride,
    input  logic [SW-1:0] frm_stride,
    input  logic          step,
    input  logic          frame_end,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - SW;

    logic [AW-1:0] cur_q, frm_q;
    logic [SW-1:0] as_q, fs_q;
    logic          const_q;
    logic [AW-1:0] as_ext, fs_ext, frame_anchor, next_frame;

    // R6: sign extension of both strides
    assign as_ext = {{EXT{as_q[SW-1]}}, as_q};
    assign fs_ext = {{EXT{fs_q[SW-1]}}, fs_q};

    // R4/R5: anchor is the last array (array sync) or the frame start (frame sync)
    assign frame_anchor = frame_sync ? frm_q : cur_q;
    assign next_frame = frame_anchor + fs_ext;
    assign addr = cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            frm_q   <= '0;
            as_q    <= '0;
            fs_q    <= '0;
            const_q <= 1'b0;
        end else if (load) begin
            cur_q   <= base;
            frm_q   <= base;
            as_q    <= arr_stride;
            fs_q    <= frm_stride;
            const_q <= hold_const;
        end else if (step && !const_q) begin
            if (frame_end) begin
                cur_q <= next_frame;
                frm_q <= next_frame;
            end else begin
                cur_q <= cur_q + as_ext;
            end
        end
    end

    // R7: a constant side never moves between loads
    p_const_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (const_q && !load) |=> $stable(addr));

endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [31:0]           cfg_opt,
    input  logic [AW-1:0]         cfg_src,
    input  logic [AW-1:0]         cfg_dst,
    input  logic [2*CW-1:0]       cfg_ab_cnt,
    input  logic [CW-1:0]         cfg_c_cnt,
    input  logic [2*CW-1:0]       cfg_a_stride,
    input  logic [2*CW-1:0]       cfg_f_stride,
    input  logic [CW-1:0]         cfg_reload,
    input  logic                  sync_evt,
    output logic                  beat_valid,
    output logic [AW-1:0]         beat_src,
    output logic [AW-1:0]         beat_dst,
    output logic [CW-1:0]         beat_bytes,
    output logic [OPT_FW_W-1:0]   beat_fifo_w,
    output logic                  busy,
    output logic                  done_pulse,
    output logic [OPT_CODE_W-1:0] done_code
);
    localparam int NSIDE = 2;

    seq_state_e state_q, state_d;
    logic       pend_q;
    logic       fsync_q, done_en_q;
    logic [CW-1:0]         acnt_q;
    logic [OPT_FW_W-1:0]   fw_q;
    logic [OPT_CODE_W-1:0] code_q;

    logic [CW-1:0] f_acnt, f_bcnt;
    logic load_ok, go, step, last_arr, last_blk, frame_end, armed;

    logic [AW-1:0] side_base  [NSIDE];
    logic [CW-1:0] side_as    [NSIDE];
    logic [CW-1:0] side_fs    [NSIDE];
    logic          side_const [NSIDE];
    logic [AW-1:0] side_addr  [NSIDE];

    logic unused_opt;
    assign unused_opt = ^{cfg_opt[31:21], cfg_opt[11], cfg_opt[7:3]};

    // R2: field split of the count word
    assign f_acnt = cfg_ab_cnt[CW-1:0];
    assign f_bcnt = cfg_ab_cnt[2*CW-1:CW];

    assign load_ok = cfg_load && (state_q == S_IDLE) && (f_acnt != '0) &&
                     (f_bcnt != '0) && (cfg_c_cnt != '0);
    assign go = sync_evt || pend_q;
    assign step = (state_q == S_ISSUE);
    assign frame_end = step && last_arr;
    assign armed = (state_q != S_IDLE);

    // side 0 is the source, side 1 the destination
    assign side_base[0]  = cfg_src;
    assign side_base[1]  = cfg_dst;
    assign side_as[0]    = cfg_a_stride[CW-1:0];
    assign side_as[1]    = cfg_a_stride[2*CW-1:CW];
    assign side_fs[0]    = cfg_f_stride[CW-1:0];
    assign side_fs[1]    = cfg_f_stride[2*CW-1:CW];
    assign side_const[0] = cfg_opt[OPT_SRC_CONST];
    assign side_const[1] = cfg_opt[OPT_DST_CONST];

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            dma3d_addr_side #(
                .AW(AW),
                .SW(CW)
            ) u_side (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (load_ok),
                .base       (side_base[s]),
                .hold_const (side_const[s]),
                .frame_sync (fsync_q),
                .arr_stride (side_as[s]),
                .frm_stride (side_fs[s]),
                .step       (step),
                .frame_end  (frame_end),
                .addr       (side_addr[s])
            );
        end
    endgenerate

    dma3d_count_ctl #(
        .CW(CW)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_ok),
        .frame_sync (cfg_opt[OPT_FRAME_SYNC]),
        .bcnt       (f_bcnt),
        .ccnt       (cfg_c_cnt),
        .reload     (cfg_reload),
        .step       (step),
        .active     (armed),
        .last_arr   (last_arr),
        .last_blk   (last_blk)
    );

    // option capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q   <= 1'b0;
            done_en_q <= 1'b0;
            acnt_q    <= '0;
            fw_q      <= '0;
            code_q    <= '0;
        end else if (load_ok) begin
            fsync_q   <= cfg_opt[OPT_FRAME_SYNC];
            done_en_q <= cfg_opt[OPT_DONE_EN];
            acnt_q    <= f_acnt;
            fw_q      <= cfg_opt[OPT_FW_LO +: OPT_FW_W];
            code_q    <= cfg_opt[OPT_CODE_LO +: OPT_CODE_W];
        end
    end

    // R10: held event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else begin
            unique case (state_q)
                S_ISSUE:  if (sync_evt) pend_q <= 1'b1;
                S_WAIT:   if (go) pend_q <= 1'b0;
                default:  pend_q <= 1'b0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (load_ok) state_d = S_WAIT;
            S_WAIT:   if (go) state_d = S_ISSUE;
            S_ISSUE: begin
                if (last_blk)
                    state_d = S_FINISH;
                else if (!fsync_q || last_arr)
                    state_d = S_WAIT;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        beat_valid  = 1'b0;
        done_pulse  = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_WAIT:   busy = 1'b1;
            S_ISSUE:  beat_valid = 1'b1;
            S_FINISH: done_pulse = done_en_q;
            default:  busy = 1'b0;
        endcase
    end

    assign beat_src    = side_addr[0];
    assign beat_dst    = side_addr[1];
    assign beat_bytes  = acnt_q;
    assign beat_fifo_w = fw_q;
    assign done_code   = code_q;

    // R3: array sync releases one beat and then stops
    p_single_array_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !fsync_q) |=> !beat_valid);

    // R9: completion is one cycle, follows a beat, then idle
    p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (!done_pulse && !busy));
    p_done_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_pulse) |-> $past(beat_valid));

    // R2: a load with a zero count leaves the block idle
    p_reject_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !busy && (f_acnt == '0)) |=> !busy);

endmodule

// File: tb/dma3d_seq_test.sv
module dma3d_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_opt = '0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [31:0] cfg_ab_cnt = '0;
    logic [15:0] cfg_c_cnt = '0;
    logic [31:0] cfg_a_stride = '0, cfg_f_stride = '0;
    logic [15:0] cfg_reload = '0;
    logic        sync_evt = 1'b0;
    logic        beat_valid, busy, done_pulse;
    logic [31:0] beat_src, beat_dst;
    logic [15:0] beat_bytes;
    logic [2:0]  beat_fifo_w;
    logic [5:0]  done_code;

    int n_cmp = 0, n_bad = 0, n_done = 0, cyc = 0;
    logic [31:0] q_src[$], q_dst[$];
    logic [15:0] exp_bytes = '0;
    logic [2:0]  exp_fw = '0;
    logic [5:0]  exp_code = '0;
    string       cur_tag = "R1";

    always #5 clk = ~clk;

    dma3d_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_opt(cfg_opt),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_ab_cnt(cfg_ab_cnt),
        .cfg_c_cnt(cfg_c_cnt), .cfg_a_stride(cfg_a_stride),
        .cfg_f_stride(cfg_f_stride), .cfg_reload(cfg_reload),
        .sync_evt(sync_evt), .beat_valid(beat_valid), .beat_src(beat_src),
        .beat_dst(beat_dst), .beat_bytes(beat_bytes),
        .beat_fifo_w(beat_fifo_w), .busy(busy), .done_pulse(done_pulse),
        .done_code(done_code)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected beats as the design presents them
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (beat_valid) begin
                if (q_src.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected beat", beat_src, 32'h0);
                end else begin
                    logic [31:0] es, ed;
                    es = q_src.pop_front();
                    ed = q_dst.pop_front();
                    chk(beat_src == es, cur_tag, "beat_src", beat_src, es);
                    chk(beat_dst == ed, cur_tag, "beat_dst", beat_dst, ed);
                    // R8
                    chk(beat_bytes == exp_bytes && beat_fifo_w == exp_fw, "R8",
                        "bytes/width", {13'd0, beat_fifo_w, beat_bytes},
                        {13'd0, exp_fw, exp_bytes});
                end
            end
            if (done_pulse) begin
                n_done++;
                chk(done_code == exp_code, "R9", "done_code", 32'(done_code), 32'(exp_code));
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_evt(input int n);
        sync_evt = 1'b1;
        tick(n);
        sync_evt = 1'b0;
    endtask

    // driver: builds the expected beat list from the requirements, then runs it
    task automatic run_xfer(input string tag, input logic [31:0] opt,
                            input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] c, input logic [15:0] sas,
                            input logic [15:0] das, input logic [15:0] sfs,
                            input logic [15:0] dfs, input logic [15:0] rld,
                            input bit pairs);
        logic [31:0] cs, cd, fs, fd;
        bit fsync;
        int total, nev, d0, w;
        fsync = opt[2];
        cs = s; cd = d; fs = s; fd = d; total = 0;
        for (int f = 0; f < int'(c); f++) begin
            int nb;
            nb = (f == 0 || fsync || rld == 0) ? int'(b) : int'(rld);
            for (int k = 0; k < nb; k++) begin
                q_src.push_back(cs);
                q_dst.push_back(cd);
                total++;
                if (k < nb - 1) begin
                    if (!opt[0]) cs = cs + {{16{sas[15]}}, sas};
                    if (!opt[1]) cd = cd + {{16{das[15]}}, das};
                end else begin
                    if (!opt[0]) begin
                        cs = (fsync ? fs : cs) + {{16{sfs[15]}}, sfs};
                        fs = cs;
                    end
                    if (!opt[1]) begin
                        cd = (fsync ? fd : cd) + {{16{dfs[15]}}, dfs};
                        fd = cd;
                    end
                end
            end
        end
        cur_tag = tag;
        exp_bytes = a; exp_fw = opt[10:8]; exp_code = opt[17:12];
        cfg_opt = opt; cfg_src = s; cfg_dst = d; cfg_ab_cnt = {b, a};
        cfg_c_cnt = c; cfg_a_stride = {das, sas}; cfg_f_stride = {dfs, sfs};
        cfg_reload = rld; cfg_load = 1'b1;
        tick(1);
        cfg_load = 1'b0;
        chk(busy == 1'b1, "R2", "busy after load", 32'(busy), 32'h1);
        d0 = n_done;
        nev = fsync ? int'(c) : total;
        for (int e = 0; e < nev; ) begin
            if (pairs && e + 1 < nev) begin
                pulse_evt(2);   // R10: second event lands on the beat cycle
                e += 2;
                tick(6);
            end else begin
                pulse_evt(1);
                e += 1;
                tick(fsync ? int'(b) + 4 : 4);
            end
        end
        w = 0;
        while (busy && w < 200) begin
            tick(1);
            w++;
        end
        chk(busy == 1'b0, tag, "busy at end", 32'(busy), 32'h0);
        chk(q_src.size() == 0, tag, "beats left unissued", 32'(q_src.size()), 32'h0);
        // R9: one pulse only when option bit 20 is set
        chk(n_done - d0 == (opt[20] ? 1 : 0), "R9", "done count",
            32'(n_done - d0), opt[20] ? 32'h1 : 32'h0);
        q_src.delete();
        q_dst.delete();
    endtask

    initial begin
        tick(1);
        // R1: reset state
        chk(busy == 1'b0 && beat_valid == 1'b0 && done_pulse == 1'b0, "R1",
            "reset outputs", {29'd0, busy, beat_valid, done_pulse}, 32'h0);
        rst_n = 1'b1;
        tick(2);

        // R11: events while idle produce nothing
        cur_tag = "R11";
        pulse_evt(3);
        tick(3);
        chk(busy == 1'b0 && beat_valid == 1'b0, "R11", "idle event",
            {30'd0, busy, beat_valid}, 32'h0);

        // R3 and R4: array sync, reload differs from first count
        run_xfer("R4", 32'h0010_5000, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd2,
                 16'd4, 16'd8, 16'h0040, 16'h0100, 16'd2, 1'b0);
        // R4: reload of zero falls back to loaded count
        run_xfer("R4", 32'h0010_7100, 32'h2000, 32'h3000, 16'd2, 16'd2, 16'd3,
                 16'd2, 16'd2, 16'd16, 16'd32, 16'd0, 1'b0);
        // R5 and R6: frame sync with negative strides
        run_xfer("R6", 32'h0010_3204, 32'h4000, 32'h9000, 16'd8, 16'd3, 16'd3,
                 16'd8, 16'hFFF8, 16'h0100, 16'hFF00, 16'd0, 1'b0);
        // R7: destination held constant, frame sync, FIFO width code 2
        run_xfer("R7", 32'h0010_0206, 32'h5000, 32'hA000, 16'd4, 16'd4, 16'd2,
                 16'd4, 16'd4, 16'd64, 16'd64, 16'd0, 1'b0);
        // R7: source held constant, array sync
        run_xfer("R7", 32'h0010_0501, 32'h5500, 32'hB000, 16'd4, 16'd2, 16'd2,
                 16'd4, 16'd4, 16'd32, 16'd32, 16'd1, 1'b0);
        // R3: zero strides keep one register address, completion disabled
        run_xfer("R3", 32'h0000_0000, 32'h6000, 32'hC000, 16'd1, 16'd2, 16'd2,
                 16'd0, 16'd0, 16'd0, 16'd0, 16'd2, 1'b0);
        // R10: back-to-back events in array sync
        run_xfer("R10", 32'h0011_1000, 32'h7000, 32'hD000, 16'd4, 16'd3, 16'd2,
                 16'd4, 16'd4, 16'd100, 16'd200, 16'd3, 1'b1);

        // R2: zero count rejected
        cur_tag = "R2";
        cfg_ab_cnt = {16'd3, 16'd0};
        cfg_c_cnt = 16'd1;
        cfg_load = 1'b1;
        tick(1);
        cfg_load = 1'b0;
        tick(1);
        chk(busy == 1'b0, "R2", "zero acnt rejected", 32'(busy), 32'h0);
        pulse_evt(1);
        tick(3);
        chk(beat_valid == 1'b0 && busy == 1'b0, "R2", "no beat after reject",
            {30'd0, busy, beat_valid}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule